// File: doc/BRIEF.md
# Cascaded Three-Bank Interrupt Controller

This block gathers interrupt requests from three banks of 32 lines each: one main bank and two sub banks. Every line has its own enable bit, a latched status bit, a trigger-style bit (edge or level) and a sense bit (rising/high or falling/low). A route bit sends the line to either the normal request or the fast request. All of these bits are reached over a simple single-cycle register bus.

Each sub bank reduces its enabled pending lines to one normal request and one fast request. These four signals enter fixed lines of the main bank and are detected there like any other input. The main bank's two reduced requests are the processor-facing outputs. Software acknowledges a line by masking it and then writing a 1 to its status bit.

Top module: `icu_cascade_top`

## Requirements
- R1: After synchronous reset, status and trigger-style registers read 0 in every bank. Sense registers read all ones (level, active high). Sub-bank enables read 0. Main enable reads 0xC0000003, which enables lines 0, 1, 30 and 31. Main route reads 0xC0000000, which sends lines 30 and 31 to the fast request. Sub-bank routes read 0.
- R2: `reg_addr[4:3]` picks the bank: 0 main, 1 sub A, 2 sub B. `reg_addr[2:0]` picks the register: 0 enable, 1 status, 2 trigger style, 3 sense, 4 route. Reads are combinational. Writes take effect at the next rising clock edge. Bank 3 and register codes 5 to 7 read as 0.
- R3: With trigger style 1 (edge), the status bit is set by the selected edge of the synchronised input. The edge is rising when sense is 1 and falling when sense is 0. A status bit set this way is readable 3 rising clock edges after the input changes. It stays set after the input returns. The opposite edge never sets it.
- R4: Writing 1 to a status bit of an edge-mode line clears it at the next edge. Writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R5: With trigger style 0 (level), status equals the input XNOR sense, 3 rising edges after the input changes. A write of 1 to status does not hold the bit low while the input is still active.
- R6: A bank's normal request is the OR of its lines that are pending, enabled and have route 0. Its fast request is the OR of its lines that are pending, enabled and have route 1.
- R7: The sub A normal and fast requests drive main lines 0 and 30. The sub B normal and fast requests drive main lines 1 and 31. The external `main_src` bits at those four positions are ignored. These lines pass through the main bank's synchroniser, so a sub-bank input reaches `irq_o`/`fiq_o` 6 rising edges after it changes.
- R8: A line whose enable bit is 0 still latches status but takes no part in either request. Acknowledging a line means masking it and then writing 1 to its status bit.
- R9: `irq_o` and `fiq_o` are the main bank's normal and fast requests. They follow its status, enable and route registers with no further register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Bank in [4:3], register in [2:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| main_src | input | 32 | Main-bank inputs; bits 0, 1, 30 and 31 unused |
| sub_a_src | input | 32 | Sub bank A inputs |
| sub_b_src | input | 32 | Sub bank B inputs |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The results fall due at different times:
- A register write is visible one rising edge after it.
- A read is visible in the same cycle.
- A main-bank input shows in status and in the outputs three edges after it changes.
- A sub-bank input reaches the outputs six edges after it changes.

The bench drives every input on the falling edge and counts rising edges to the due cycle. It samples on the falling edge after that rising edge. For both the direct and the cascaded paths it also samples one edge early and expects the old value, so a pipeline that is one stage too short or too long is caught.

// File: rtl/icu_pkg.sv
`timescale 1ns/1ps
package icu_pkg;

    localparam int BANK_AW = 2;
    localparam int REG_AW  = 3;
    localparam int ADDR_W  = BANK_AW + REG_AW;

    typedef enum logic [REG_AW-1:0] {
        REG_ENABLE = 3'd0,
        REG_STATUS = 3'd1,
        REG_TYPE   = 3'd2,
        REG_SENSE  = 3'd3,
        REG_ROUTE  = 3'd4
    } reg_sel_e;

    typedef enum logic [BANK_AW-1:0] {
        BANK_MAIN  = 2'd0,
        BANK_SUB_A = 2'd1,
        BANK_SUB_B = 2'd2
    } bank_e;

    typedef struct packed {
        logic irq;
        logic fiq;
    } req_t;

    function automatic bank_e addr_bank(input logic [ADDR_W-1:0] a);
        return bank_e'(a[ADDR_W-1:REG_AW]);
    endfunction

    function automatic reg_sel_e addr_reg(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[REG_AW-1:0]);
    endfunction

endpackage

// File: rtl/icu_sync.sv
`timescale 1ns/1ps
module icu_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/icu_line_detect.sv
`timescale 1ns/1ps
module icu_line_detect (
    input  logic clk,
    input  logic rst,
    input  logic in_sync,
    input  logic edge_mode,
    input  logic sense_high,
    input  logic clr,
    output logic status
);
    logic act;
    logic act_q;
    logic edge_ev;

    assign act     = sense_high ? in_sync : ~in_sync;
    assign edge_ev = act & ~act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            status <= 1'b0;
        end else begin
            act_q <= act;
            if (edge_mode) status <= (status & ~clr) | edge_ev;
            else           status <= act;
        end
    end

    // R3
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && edge_ev) |=> status);

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && status && !clr) |=> status);

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && clr && !edge_ev) |=> !status);

    // R5
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode) |=> (status == $past(act)));
endmodule

// File: rtl/icu_bank.sv
`timescale 1ns/1ps
module icu_bank
    import icu_pkg::*;
#(
    parameter int                NLINES      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [NLINES-1:0] EN_RST      = '0,
    parameter logic [NLINES-1:0] ROUTE_RST   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] src,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [NLINES-1:0] wr_data,
    output logic [NLINES-1:0] rd_data,
    output req_t              req
);
    logic [NLINES-1:0] en_r, type_r, sense_r, route_r;
    logic [NLINES-1:0] src_s, status, clr;
    logic [NLINES-1:0] live;

    icu_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src),
        .q   (src_s)
    );

    assign clr = (wr_en && sel == REG_STATUS) ? wr_data : '0;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        icu_line_detect u_det (
            .clk        (clk),
            .rst        (rst),
            .in_sync    (src_s[i]),
            .edge_mode  (type_r[i]),
            .sense_high (sense_r[i]),
            .clr        (clr[i]),
            .status     (status[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_r    <= EN_RST;
            type_r  <= '0;
            sense_r <= '1;
            route_r <= ROUTE_RST;
        end else if (wr_en) begin
            case (sel)
                REG_ENABLE: en_r    <= wr_data;
                REG_TYPE:   type_r  <= wr_data;
                REG_SENSE:  sense_r <= wr_data;
                REG_ROUTE:  route_r <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            REG_ENABLE: rd_data = en_r;
            REG_STATUS: rd_data = status;
            REG_TYPE:   rd_data = type_r;
            REG_SENSE:  rd_data = sense_r;
            REG_ROUTE:  rd_data = route_r;
            default:    rd_data = '0;
        endcase
    end

    assign live    = status & en_r;
    assign req.irq = |(live & ~route_r);
    assign req.fiq = |(live & route_r);

    // R8
    mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en_r == '0) |-> (!req.irq && !req.fiq));
endmodule

// File: rtl/icu_cascade_top.sv
`timescale 1ns/1ps
module icu_cascade_top
    import icu_pkg::*;
#(
    parameter int NLINES      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NLINES-1:0] reg_wdata,
    output logic [NLINES-1:0] reg_rdata,
    input  logic [NLINES-1:0] main_src,
    input  logic [NLINES-1:0] sub_a_src,
    input  logic [NLINES-1:0] sub_b_src,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int NSUB       = 2;
    localparam int CASC_IRQ_A = 0;
    localparam int CASC_IRQ_B = 1;
    localparam int CASC_FIQ_A = NLINES - 2;
    localparam int CASC_FIQ_B = NLINES - 1;
    localparam logic [NLINES-1:0] ONE       = NLINES'(1);
    localparam logic [NLINES-1:0] FIQ_MASK  = (ONE << CASC_FIQ_A) | (ONE << CASC_FIQ_B);
    localparam logic [NLINES-1:0] CASC_MASK = (ONE << CASC_IRQ_A) | (ONE << CASC_IRQ_B) | FIQ_MASK;

    bank_e             bank_idx;
    reg_sel_e          reg_idx;
    logic [NLINES-1:0] sub_src [NSUB];
    logic [NLINES-1:0] sub_rd  [NSUB];
    req_t              sub_req [NSUB];
    logic [NLINES-1:0] main_mix;
    logic [NLINES-1:0] main_rd;
    req_t              main_req;

    assign bank_idx   = addr_bank(reg_addr);
    assign reg_idx    = addr_reg(reg_addr);
    assign sub_src[0] = sub_a_src;
    assign sub_src[1] = sub_b_src;

    for (genvar s = 0; s < NSUB; s++) begin : g_sub
        icu_bank #(
            .NLINES      (NLINES),
            .SYNC_STAGES (SYNC_STAGES),
            .EN_RST      ('0),
            .ROUTE_RST   ('0)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .src     (sub_src[s]),
            .wr_en   (reg_wr && bank_idx == bank_e'(s + 1)),
            .sel     (reg_idx),
            .wr_data (reg_wdata),
            .rd_data (sub_rd[s]),
            .req     (sub_req[s])
        );
    end

    always_comb begin
        main_mix             = main_src;
        main_mix[CASC_IRQ_A] = sub_req[0].irq;
        main_mix[CASC_IRQ_B] = sub_req[1].irq;
        main_mix[CASC_FIQ_A] = sub_req[0].fiq;
        main_mix[CASC_FIQ_B] = sub_req[1].fiq;
    end

    icu_bank #(
        .NLINES      (NLINES),
        .SYNC_STAGES (SYNC_STAGES),
        .EN_RST      (CASC_MASK),
        .ROUTE_RST   (FIQ_MASK)
    ) u_main (
        .clk     (clk),
        .rst     (rst),
        .src     (main_mix),
        .wr_en   (reg_wr && bank_idx == BANK_MAIN),
        .sel     (reg_idx),
        .wr_data (reg_wdata),
        .rd_data (main_rd),
        .req     (main_req)
    );

    always_comb begin
        case (bank_idx)
            BANK_MAIN:  reg_rdata = main_rd;
            BANK_SUB_A: reg_rdata = sub_rd[0];
            BANK_SUB_B: reg_rdata = sub_rd[1];
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_o = main_req.irq;
    assign fiq_o = main_req.fiq;
endmodule

// File: tb/icu_cascade_top_tb.sv
`timescale 1ns/1ps
module icu_cascade_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] NC = 32'h3FFF_FFFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] main_src = '0, sub_a_src = '0, sub_b_src = '0;
    logic        irq_o, fiq_o;
    int          n_tests = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icu_cascade_top u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .main_src(main_src),
        .sub_a_src(sub_a_src), .sub_b_src(sub_b_src), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int b, input int s, input logic [31:0] d);
        reg_addr  = {b[1:0], s[2:0]};
        reg_wdata = d;
        reg_wr    = 1'b1;
        cyc(1);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int b, input int s, output logic [31:0] d);
        reg_addr = {b[1:0], s[2:0]};
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [1:0] exp_req(input logic [31:0] st, input logic [31:0] en,
                                           input logic [31:0] rt);
        return {|(st & en & ~rt), |(st & en & rt)};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(0, 0, v); check("R1 main enable", v, 32'hC000_0003);
        rd(0, 4, v); check("R1 main route", v, 32'hC000_0000);
        rd(1, 0, v); check("R1 subA enable", v, 32'h0);
        rd(2, 4, v); check("R1 subB route", v, 32'h0);
        rd(0, 2, v); check("R1 main type", v, 32'h0);
        rd(1, 3, v); check("R1 subA sense", v, 32'hFFFF_FFFF);
        rd(0, 1, v); check("R1 main status", v, 32'h0);
        check("R1 irq/fiq", {30'd0, irq_o, fiq_o}, 32'h0);

        // R2 decode
        rd(3, 0, v); check("R2 bank3 read", v, 32'h0);
        rd(0, 6, v); check("R2 unmapped reg", v, 32'h0);

        main_src = 32'h0000_0280;
        cyc(4);
        wr(0, 3, ~32'h0000_0280);
        wr(0, 2, 32'h0000_00A0);
        wr(0, 0, 32'hC000_0023);
        rd(0, 2, v); check("R2 type readback", v, 32'h0000_00A0);

        // R3 rising edge on line 5
        main_src[5] = 1'b1;
        cyc(2);
        rd(0, 1, v); check("R3 not yet after 2 edges", v & 32'h20, 32'h0);
        cyc(1);
        rd(0, 1, v); check("R3 rising sets after 3 edges", v & 32'h20, 32'h20);
        check("R9 irq_o raised", {31'd0, irq_o}, 32'h1);
        main_src[5] = 1'b0;
        cyc(4);
        rd(0, 1, v); check("R3 sticky after input drop", v & 32'h20, 32'h20);

        // R4 write-one-to-clear
        wr(0, 1, 32'h0);
        rd(0, 1, v); check("R4 write 0 no effect", v & 32'h20, 32'h20);
        wr(0, 1, 32'h20);
        rd(0, 1, v); check("R4 write 1 clears", v & 32'h20, 32'h0);
        check("R4 irq_o dropped", {31'd0, irq_o}, 32'h0);

        // R3 falling edge on line 7
        main_src[7] = 1'b0;
        cyc(3);
        rd(0, 1, v); check("R3 falling sets", v & 32'h80, 32'h80);
        wr(0, 1, 32'h80);
        main_src[7] = 1'b1;
        cyc(4);
        rd(0, 1, v); check("R3 opposite edge ignored", v & 32'h80, 32'h0);

        // R5 level active low on line 9
        main_src[9] = 1'b0;
        cyc(3);
        rd(0, 1, v); check("R5 low level pending", v & 32'h200, 32'h200);
        wr(0, 1, 32'h200);
        rd(0, 1, v); check("R5 clear ignored while active", v & 32'h200, 32'h200);
        main_src[9] = 1'b1;
        cyc(3);
        rd(0, 1, v); check("R5 follows inactive input", v & 32'h200, 32'h0);

        // R6 routing line 5 to fast request
        wr(0, 4, 32'hC000_0020);
        main_src[5] = 1'b1;
        cyc(3);
        check("R6 fast route", {30'd0, irq_o, fiq_o}, 32'h1);
        main_src[5] = 1'b0;
        wr(0, 1, 32'h20);
        check("R6 fast cleared", {30'd0, irq_o, fiq_o}, 32'h0);

        // R8 masked line 11 latches but stays quiet
        main_src[11] = 1'b1;
        cyc(3);
        rd(0, 1, v); check("R8 masked still latches", v & 32'h800, 32'h800);
        check("R8 masked no request", {31'd0, irq_o}, 32'h0);
        wr(0, 0, 32'hC000_0823);
        check("R8 unmask raises irq", {31'd0, irq_o}, 32'h1);
        wr(0, 0, 32'hC000_0023);
        check("R8 ack mask drops irq", {31'd0, irq_o}, 32'h0);
        wr(0, 1, 32'h800);
        main_src[11] = 1'b0;
        cyc(3);
        rd(0, 1, v); check("R8 ack done", v & 32'h800, 32'h0);

        // R7 cascade sub A normal -> main line 0
        wr(1, 0, 32'h8);
        sub_a_src[3] = 1'b1;
        cyc(5);
        check("R7 cascade not yet at 5 edges", {31'd0, irq_o}, 32'h0);
        cyc(1);
        check("R7 cascade irq at 6 edges", {31'd0, irq_o}, 32'h1);
        rd(0, 1, v); check("R7 main line 0 pending", v & 32'h1, 32'h1);
        rd(1, 1, v); check("R7 subA line 3 pending", v & 32'h8, 32'h8);
        sub_a_src[3] = 1'b0;
        cyc(6);
        check("R7 cascade irq released", {31'd0, irq_o}, 32'h0);

        // R7 cascade sub B fast -> main line 31
        wr(2, 0, 32'h10);
        wr(2, 4, 32'h10);
        sub_b_src[4] = 1'b1;
        cyc(6);
        check("R7 subB fast cascade", {30'd0, irq_o, fiq_o}, 32'h1);
        rd(0, 1, v); check("R7 main line 31 pending", v & 32'h8000_0000, 32'h8000_0000);
        sub_b_src[4] = 1'b0;
        cyc(6);

        // R7 external bits on cascade lines ignored
        main_src = main_src | 32'h4000_0003;
        cyc(4);
        rd(0, 1, v); check("R7 external cascade bits ignored", v & 32'hC000_0003, 32'h0);
        check("R7 outputs quiet", {30'd0, irq_o, fiq_o}, 32'h0);

        // R5/R6 random level-mode patterns on main lines 2..29
        wr(0, 2, 32'h0);
        for (int it = 0; it < 24; it++) begin
            logic [31:0] en, rt, pol, src, act;
            logic [1:0]  e;
            en  = $urandom;
            rt  = $urandom;
            pol = $urandom | 32'hC000_0003;
            src = $urandom;
            wr(0, 0, en);
            wr(0, 4, rt);
            wr(0, 3, pol);
            main_src = src;
            cyc(4);
            act = ~(src ^ pol) & NC;
            e   = exp_req(act, en, rt);
            rd(0, 1, v); check("R5 random level status", v, act);
            check("R6 random requests", {30'd0, irq_o, fiq_o}, {30'd0, e});
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : seed
        process::self().srandom(32'd1234);
    end
endmodule